// File: doc/BRIEF.md
# Pixel Stream Backpressure FIFO

This block is a single-clock first-in first-out buffer that sits between an upstream pixel source and downstream pixel logic. Each stored entry carries one pixel word together with four frame-position flags (line begin, line end, frame begin, frame end). Any beat presented with its valid flag high is written, whatever the block's own ready output shows. The four flags leave the block in lockstep with the pixel word they arrived with.

Backpressure to the source works from a threshold set below the full level. The registered ready output falls once the fill level reaches `AF_LEVEL`. The source can take several cycles to react to that, and the block keeps storing the beats that are still in flight until it holds `DEPTH` entries. A beat arriving at true full is discarded unless a read frees a slot in the same cycle. Every discard sets a sticky overflow flag. The head entry is shown on the output continuously. A transfer occurs, and the output valid is raised, only in a cycle where the downstream ready input is high and the buffer is not empty.

Top module: `pix_backpressure_fifo`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge) the buffer is empty, `snk_vld` is 0 even when `snk_rdy` is 1, `src_rdy` is 1 and `ovf_sticky` is 0.
- R2: A beat is written only when `src_vld` is 1. Beats with `src_vld` at 0 store nothing, so none of them ever appears at the output.
- R3: `src_rdy` is a registered output equal to 1 exactly when the occupancy is below `AF_LEVEL` (default 8). It falls in the cycle after the write that brings the occupancy to `AF_LEVEL`, and it rises in the cycle after a read that brings the occupancy back below `AF_LEVEL`.
- R4: While `src_rdy` is 0 the block keeps accepting valid beats until it holds `DEPTH` entries (default 16). The occupancy never exceeds `DEPTH`.
- R5: A valid beat that arrives while `DEPTH` entries are held, in a cycle with no read, is dropped and never delivered. `ovf_sticky` goes to 1 at the next edge and stays at 1 until reset.
- R6: A write and a read in the same cycle leave the occupancy unchanged. At full this means the incoming beat is stored and nothing is dropped.
- R7: `snk_vld` is 1 only in a cycle where the buffer is non-empty and `snk_rdy` is 1. While `snk_rdy` is 0, the head word on `snk_pix` and the flag outputs holds its value.
- R8: Entries leave in arrival order. `snk_pix` has the same width `PIX_W` as `src_pix`, and each of `snk_hbeg`, `snk_hend`, `snk_vbeg` and `snk_vend` equals the flag that entered with that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_pix | input | PIX_W | Incoming pixel word |
| src_hbeg | input | 1 | Incoming first pixel of a line |
| src_hend | input | 1 | Incoming last pixel of a line |
| src_vbeg | input | 1 | Incoming first line of a frame |
| src_vend | input | 1 | Incoming last line of a frame |
| src_vld | input | 1 | Incoming beat valid |
| snk_rdy | input | 1 | Downstream can take a pixel this cycle |
| snk_pix | output | PIX_W | Head pixel word |
| snk_hbeg | output | 1 | Head line-begin flag |
| snk_hend | output | 1 | Head line-end flag |
| snk_vbeg | output | 1 | Head frame-begin flag |
| snk_vend | output | 1 | Head frame-end flag |
| snk_vld | output | 1 | Pixel transferred downstream this cycle |
| src_rdy | output | 1 | Source may send (occupancy below threshold) |
| ovf_sticky | output | 1 | A beat has been dropped since reset |

## Verification
The assertions assume that `src_vld` and `snk_rdy` carry known values from the first cycle after reset. They also assume `1 <= AF_LEVEL < DEPTH`, so that the threshold comparison and the bound on the fill level make sense. They do not assume that the source obeys `src_rdy`. The stimulus therefore deliberately keeps writing while `src_rdy` is low, both to reach true full and to force drops. All inputs change only on the falling clock edge, so every property sees settled, defined values at the rising edge.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

  typedef struct packed {
    logic line_beg;
    logic line_end;
    logic frm_beg;
    logic frm_end;
  } pbf_tags_t;

  localparam int TAG_W = $bits(pbf_tags_t);

  // next slot index with wrap at the buffer depth
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // fill level after one cycle of optional write and optional read
  function automatic int unsigned level_next(int unsigned lvl, logic wr, logic rd);
    case ({wr, rd})
      2'b10:   return lvl + 1;
      2'b01:   return lvl - 1;
      default: return lvl;
    endcase
  endfunction

endpackage

// File: rtl/pbf_ptr.sv
module pbf_ptr #(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  import pbf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= PW'(wrap_inc(int'(ptr), DEPTH));
  end

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < DEPTH);

endmodule

// File: rtl/pbf_level.sv
module pbf_level #(
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 8,
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic rd_req,
  output logic empty,
  output logic do_wr,
  output logic do_rd,
  output logic drop,
  output logic up_rdy,
  output logic ovf
);
  import pbf_pkg::*;

  logic [CW-1:0] lvl, lvl_nxt;
  logic          full;

  assign empty   = (lvl == '0);
  assign full    = (lvl == CW'(DEPTH));
  assign do_rd   = !empty && rd_req;
  assign do_wr   = wr_req && (!full || do_rd);
  assign drop    = wr_req && !do_wr;
  assign lvl_nxt = CW'(level_next(int'(lvl), do_wr, do_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl    <= '0;
      up_rdy <= 1'b1;
      ovf    <= 1'b0;
    end else begin
      lvl    <= lvl_nxt;
      up_rdy <= (lvl_nxt < CW'(AF_LEVEL));
      if (drop) ovf <= 1'b1;
    end
  end

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    lvl <= CW'(DEPTH));
  assert_ready_tracks_level_R3: assert property (@(posedge clk) disable iff (rst)
    up_rdy == (lvl < CW'(AF_LEVEL)));
  assert_drop_only_full_R5: assert property (@(posedge clk) disable iff (rst)
    drop |-> full && !rd_req);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_ovf_on_drop_R5: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);
  assert_both_hold_level_R6: assert property (@(posedge clk) disable iff (rst)
    (do_wr && do_rd) |=> $stable(lvl));
  assert_full_swap_no_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && rd_req) |-> do_wr);

endmodule

// File: rtl/pbf_store.sv
module pbf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pix_backpressure_fifo.sv
module pix_backpressure_fifo #(
  parameter int PIX_W    = 8,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] src_pix,
  input  logic             src_hbeg,
  input  logic             src_hend,
  input  logic             src_vbeg,
  input  logic             src_vend,
  input  logic             src_vld,
  input  logic             snk_rdy,
  output logic [PIX_W-1:0] snk_pix,
  output logic             snk_hbeg,
  output logic             snk_hend,
  output logic             snk_vbeg,
  output logic             snk_vend,
  output logic             snk_vld,
  output logic             src_rdy,
  output logic             ovf_sticky
);
  import pbf_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int W  = PIX_W + TAG_W;

  logic          empty, do_wr, do_rd, drop;
  logic [PW-1:0] wr_ptr, rd_ptr;
  pbf_tags_t     in_tags, head_tags;
  logic [W-1:0]  in_word, head_word;

  assign in_tags = '{line_beg: src_hbeg, line_end: src_hend,
                     frm_beg: src_vbeg, frm_end: src_vend};
  assign in_word = {in_tags, src_pix};

  pbf_level #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_level (
    .clk(clk), .rst(rst), .wr_req(src_vld), .rd_req(snk_rdy),
    .empty(empty), .do_wr(do_wr), .do_rd(do_rd), .drop(drop),
    .up_rdy(src_rdy), .ovf(ovf_sticky)
  );

  pbf_ptr #(.DEPTH(DEPTH)) u_wptr (.clk(clk), .rst(rst), .adv(do_wr), .ptr(wr_ptr));
  pbf_ptr #(.DEPTH(DEPTH)) u_rptr (.clk(clk), .rst(rst), .adv(do_rd), .ptr(rd_ptr));

  pbf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .we(do_wr), .waddr(wr_ptr), .wdata(in_word),
    .raddr(rd_ptr), .rdata(head_word)
  );

  assign head_tags = pbf_tags_t'(head_word[W-1:PIX_W]);
  assign snk_pix   = head_word[PIX_W-1:0];
  assign snk_hbeg  = head_tags.line_beg;
  assign snk_hend  = head_tags.line_end;
  assign snk_vbeg  = head_tags.frm_beg;
  assign snk_vend  = head_tags.frm_end;
  assign snk_vld   = do_rd;

  assert_valid_needs_ready_R7: assert property (@(posedge clk) disable iff (rst)
    snk_vld |-> snk_rdy);
  assert_head_held_R7: assert property (@(posedge clk) disable iff (rst)
    (!empty && !snk_rdy) |=> $stable(head_word));
  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    !src_vld |-> !do_wr);

endmodule

// File: tb/sim_pix_backpressure_fifo.sv
module sim_pix_backpressure_fifo;
  localparam int PW_ = 8;
  localparam int D   = 16;
  localparam int AF  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic [PW_-1:0] src_pix = '0;
  logic          src_hbeg = 0, src_hend = 0, src_vbeg = 0, src_vend = 0;
  logic          src_vld = 0, snk_rdy = 0;
  logic [PW_-1:0] snk_pix;
  logic          snk_hbeg, snk_hend, snk_vbeg, snk_vend, snk_vld, src_rdy, ovf_sticky;

  pix_backpressure_fifo #(.PIX_W(PW_), .DEPTH(D), .AF_LEVEL(AF)) u0 (
    .clk(clk), .rst(rst), .src_pix(src_pix), .src_hbeg(src_hbeg), .src_hend(src_hend),
    .src_vbeg(src_vbeg), .src_vend(src_vend), .src_vld(src_vld), .snk_rdy(snk_rdy),
    .snk_pix(snk_pix), .snk_hbeg(snk_hbeg), .snk_hend(snk_hend), .snk_vbeg(snk_vbeg),
    .snk_vend(snk_vend), .snk_vld(snk_vld), .src_rdy(src_rdy), .ovf_sticky(ovf_sticky)
  );

  int checks = 0, fails = 0;
  int mcount = 0, popped = 0;
  bit mdrop  = 0;
  logic [PW_+3:0] sb [$];
  logic [PW_-1:0] seq = 8'h01;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies one beat; scoreboard push happens in the model step
  task automatic drive(logic v, logic [PW_-1:0] p, logic [3:0] f, logic r);
    src_vld = v; src_pix = p;
    {src_hbeg, src_hend, src_vbeg, src_vend} = f;
    snk_rdy = r;
  endtask

  // monitor: compares outputs with the model just before the edge
  task automatic monitor(logic v, logic r);
    bit exp_vld;
    bit wr;
    logic [PW_+3:0] got;
    exp_vld = (mcount > 0) && r;
    got = {snk_hbeg, snk_hend, snk_vbeg, snk_vend, snk_pix};
    chk(snk_vld == exp_vld, "R7", "snk_vld", snk_vld, exp_vld);
    chk(src_rdy == (mcount < AF), "R3", "src_rdy", src_rdy, mcount < AF);
    chk(ovf_sticky == mdrop, "R5", "ovf_sticky", ovf_sticky, mdrop);
    if (mcount > 0)
      chk(got == sb[0], "R8", "head word", got, sb[0]);
    if (exp_vld) begin
      void'(sb.pop_front());
      popped++;
    end
    wr = v && (mcount < D || exp_vld);
    if (wr) sb.push_back({src_hbeg, src_hend, src_vbeg, src_vend, src_pix});
    else if (v) mdrop = 1;
    mcount = mcount + (wr ? 1 : 0) - (exp_vld ? 1 : 0);
  endtask

  task automatic step(logic v, logic r);
    logic [3:0] f;
    f = {seq[0], seq[3], seq[5], seq[6]};
    drive(v, seq, f, r);
    if (v) seq = seq * 8'd37 + 8'd11;
    #1;
    monitor(v, r);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(0, '0, '0, 1'b1);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mcount = 0; mdrop = 0; sb.delete();
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state with downstream ready
    #1;
    chk(snk_vld == 0, "R1", "snk_vld after reset", snk_vld, 0);
    chk(src_rdy == 1, "R1", "src_rdy after reset", src_rdy, 1);
    chk(ovf_sticky == 0, "R1", "ovf after reset", ovf_sticky, 0);
    @(negedge clk);

    // R2: invalid beats interleaved with valid ones, downstream stalled
    for (int i = 0; i < 10; i++) step(i % 2 == 0, 0);
    popped = 0;
    for (int i = 0; i < 8; i++) step(0, 1);
    chk(popped == 5, "R2", "items from 10 beats with 5 valid", popped, 5);

    // R3/R4: fill past threshold to full while stalled
    for (int i = 0; i < 7; i++) step(1, 0);
    #0 chk(src_rdy == 1, "R3", "src_rdy at 7 entries", src_rdy, 1);
    step(1, 0);
    chk(src_rdy == 0, "R3", "src_rdy at threshold", src_rdy, 0);
    for (int i = 0; i < 8; i++) step(1, 0);
    // R6: write and read together at full
    step(1, 1);
    step(0, 0);
    chk(ovf_sticky == 0, "R6", "no drop on swap at full", ovf_sticky, 0);
    popped = 0;
    for (int i = 0; i < 20; i++) step(0, 1);
    chk(popped == D, "R4", "entries held at full", popped, D);

    // R5: overfill while stalled
    for (int i = 0; i < D + 3; i++) step(1, 0);
    chk(ovf_sticky == 1, "R5", "ovf after drops", ovf_sticky, 1);
    popped = 0;
    for (int i = 0; i < 10; i++) step(0, 1);
    chk(src_rdy == 1, "R3", "src_rdy back after drain", src_rdy, 1);
    for (int i = 0; i < 10; i++) step(0, 1);
    chk(popped == D, "R5", "dropped beats not delivered", popped, D);
    chk(ovf_sticky == 1, "R5", "ovf stays set", ovf_sticky, 1);
    do_reset();
    #1 chk(ovf_sticky == 0, "R5", "ovf cleared by reset", ovf_sticky, 0);
    @(negedge clk);

    // mixed stream: R7 hold and R8 ordering under varying patterns
    begin
      logic [7:0] lf;
      lf = 8'hA5;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        step(lf[0] | lf[2], (i < 300) ? lf[1] : (lf[1] | lf[6]));
      end
    end
    for (int i = 0; i < 20; i++) step(0, 1);
    chk(mcount == 0 && snk_vld == 0, "R8", "stream drained", snk_vld, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule